// File: doc/BRIEF.md
# Interleaved Multiphase PWM Sequencer

This block drives up to four PWM lines for a multiphase buck converter from one system clock. A free-running period counter produces one termination tick per active channel in each switching period. The ticks are spread evenly across the period, so the falling edges of the channels interleave. A termination always forces its line low. The line then stays low for a mandatory off window of one third of the period. When the window closes, the channel emits a one-cycle sample strobe for the current-sense path. After that, a per-channel turn-on request, which stands in for the external loop comparator, may raise the line again. The line stays high until the next termination.

The period, in clock ticks, and the per-channel "unused" straps are captured only while reset is held low. The straps select two, three or four active channels, and the channel count sets both the tick spacing and the firing order. Channels that are not in use stay quiet. The period must be at least 8 ticks.

Top module: `mphase_pwm_seq`

## Requirements
- R1: While `rst_n` is low, every PWM line and strobe is 0. `period_i` and `unused_i` are captured only during reset, and changes to them after reset have no effect on the outputs.
- R2: The channel count is decided by the straps. With `unused_i[2]` set, channels 0 and 1 are active (two-channel mode), whatever `unused_i[3]` holds. Otherwise, with `unused_i[3]` set, channels 0 to 2 are active. With neither strap set, all four channels are active.
- R3: In four-channel mode, with P the captured period and step = P>>2: channel 3 terminates on the first clock edge after reset release (edge 0), channel 2 at edge step, channel 1 at 2*step and channel 0 at 3*step.
- R4: In three-channel mode, with step = P/3 truncated: channel 2 terminates at edge 0, channel 1 at step and channel 0 at 2*step.
- R5: In two-channel mode, channel 1 terminates at edge 0 and channel 0 at edge P>>1.
- R6: Each active channel terminates again every P edges after its first termination. A termination edge always leaves that PWM line at 0.
- R7: After a termination at edge T, the line stays 0 through edge T+P/3, whatever the turn-on request does.
- R8: A sample strobe is 1 for exactly the one cycle after edge T+P/3, and it is 0 at all other times.
- R9: After the window, if the request is 1 at an edge, the line is 1 from that edge until the next termination. A request that is dropped before the window closes has no effect.
- R10: An inactive channel keeps its PWM line and strobe at 0.
- R11: Between reset release and its first termination, an active channel is already enabled and follows R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps and period are captured while it is low |
| period_i | input | 16 | Switching period in clock ticks (at least 8) |
| unused_i | input | 4 | Per-channel "unused" straps; only bits 2 and 3 select the mode |
| turn_on_i | input | 4 | Per-channel turn-on requests |
| pwm_o | output | 4 | PWM lines, bit n is channel n |
| sample_o | output | 4 | One-cycle current-sample strobes at the end of each forced-off window |

## Verification
A wrong counter or offset moves a falling edge of a PWM line away from its computed edge. This shows up within one switching period of reset release, because every active channel terminates once in its first period. A wrong forced-off count shows up in the same period: the strobe appears on the wrong edge, or a line rises while the window should still hold it low. A wrong strap decode shows up even earlier, as an inactive line going high or an active line refusing a request before its first termination.

// File: rtl/mphase_pwm_pkg.sv
// Shared constants and types for the interleaved multiphase PWM sequencer.
// Assumes a fixed maximum of four channels; the strap decode relies on it.
package mphase_pwm_pkg;
    localparam int CH_MAX = 4;
    localparam int CNT_W  = 3;   // holds an active-channel count of up to 4

    typedef enum logic [1:0] {
        CH_ENABLED = 2'd0,  // window closed, waiting for a turn-on request
        CH_HIGH    = 2'd1,  // line driven high, waiting for termination
        CH_HOLDOFF = 2'd2   // forced-off window running
    } chan_state_e;
endpackage

// File: rtl/mphase_cfg_latch.sv
// Captures the period and the straps while reset is low, then derives the
// active-channel count, the active mask, the tick spacing and the off window.
// Assumes the period is at least 8 so that spacings and window are non-zero.
module mphase_cfg_latch
    import mphase_pwm_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PW-1:0]            period_i,
    input  logic [CH_MAX-1:0]        unused_i,
    output logic [PW-1:0]            period_o,
    output logic [CNT_W-1:0]         nact_o,
    output logic [CH_MAX-1:0]        active_o,
    output logic [PW-1:0]            step_o,
    output logic [PW-1:0]            toff_o
);
    logic [PW-1:0]     period_q;
    logic [CH_MAX-1:0] strap_q;

    // Capture: load configuration only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= period_i;
            strap_q  <= unused_i;
        end
    end

    // Mode decode: the bit-2 strap wins over the bit-3 strap.
    always_comb begin
        if (strap_q[2])      nact_o = CNT_W'(2);
        else if (strap_q[3]) nact_o = CNT_W'(3);
        else                 nact_o = CNT_W'(4);
    end

    // Spacing: one period divided by the channel count, truncated.
    always_comb begin
        case (nact_o)
            CNT_W'(2): step_o = period_q >> 1;
            CNT_W'(3): step_o = period_q / PW'(3);
            default:   step_o = period_q >> 2;
        endcase
    end

    // Forced-off window is one third of the period, truncated.
    assign toff_o   = period_q / PW'(3);
    assign period_o = period_q;

    for (genvar g = 0; g < CH_MAX; g++) begin : g_act
        assign active_o[g] = (CNT_W'(g) < nact_o);
    end

    // R1: configuration stays frozen once reset is released.
    assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(period_q) && $stable(strap_q)));
endmodule

// File: rtl/mphase_phase_timer.sv
// Period counter plus per-channel termination tick decode. Slot k of the
// firing order fires at count k*step. The highest active channel takes
// slot 0, so channels fire in descending order. Assumes the period is at
// least 8, which keeps all slot counts distinct and below the period.
module mphase_phase_timer
    import mphase_pwm_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PW-1:0]            period_i,
    input  logic [PW-1:0]            step_i,
    input  logic [CNT_W-1:0]         nact_i,
    input  logic [CH_MAX-1:0]        active_i,
    output logic [CH_MAX-1:0]        tick_o
);
    logic [PW-1:0] cnt_q;

    // Period counter: wraps at period-1 and starts at 0 out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (cnt_q == period_i - PW'(1)) cnt_q <= '0;
        else                                cnt_q <= cnt_q + PW'(1);
    end

    for (genvar g = 0; g < CH_MAX; g++) begin : g_slot
        logic [CNT_W-1:0] slot;
        logic [PW-1:0]    offs;

        // Slot index within the firing order for this channel.
        assign slot = nact_i - CNT_W'(1) - CNT_W'(g);

        // Offset: slot times the spacing, built from additions.
        always_comb begin
            case (slot)
                CNT_W'(0): offs = '0;
                CNT_W'(1): offs = step_i;
                CNT_W'(2): offs = step_i + step_i;
                default:   offs = step_i + step_i + step_i;
            endcase
        end

        assign tick_o[g] = active_i[g] && (cnt_q == offs);
    end

    // R3: at most one channel terminates on any edge.
    assert_single_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tick_o));
    // R6: the counter never reaches the period.
    assert_cnt_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < period_i);
endmodule

// File: rtl/mphase_chan_ctl.sv
// One PWM channel. A termination tick forces the line low and starts the
// off window. When the window ends the channel strobes for one cycle and
// becomes enabled. A request seen while enabled raises the line.
// Assumes the off window is at least one tick long.
module mphase_chan_ctl
    import mphase_pwm_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active_i,
    input  logic           tick_i,
    input  logic [PW-1:0]  toff_i,
    input  logic           turn_on_i,
    output logic           pwm_o,
    output logic           sample_o
);
    chan_state_e   st_q;
    logic [PW-1:0] left_q;

    // Channel sequencing: termination first, then window, then enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            st_q     <= CH_ENABLED;
            left_q   <= '0;
            pwm_o    <= 1'b0;
            sample_o <= 1'b0;
        end else begin
            sample_o <= 1'b0;
            if (tick_i) begin
                st_q   <= CH_HOLDOFF;
                left_q <= toff_i;
                pwm_o  <= 1'b0;
            end else begin
                case (st_q)
                    CH_HOLDOFF: begin
                        if (left_q <= PW'(1)) begin
                            st_q     <= CH_ENABLED;
                            sample_o <= 1'b1;
                        end else begin
                            left_q <= left_q - PW'(1);
                        end
                    end
                    CH_ENABLED: begin
                        if (turn_on_i) begin
                            st_q  <= CH_HIGH;
                            pwm_o <= 1'b1;
                        end
                    end
                    CH_HIGH: ;
                    default: st_q <= CH_ENABLED;
                endcase
            end
        end
    end

    // R6: a termination edge leaves the line low.
    assert_low_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> !pwm_o);
    // R7: the line is low for the whole window.
    assert_low_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_HOLDOFF) |-> !pwm_o);
    // R8: the strobe lasts one cycle and comes only while the line is low.
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);
    assert_strobe_line_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> !pwm_o);
    // R9: the line rises only after a request.
    assert_rise_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> $past(turn_on_i));
    // R10: an inactive channel is quiet.
    assert_inactive_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!active_i) |-> (!pwm_o && !sample_o));
endmodule

// File: rtl/mphase_pwm_seq.sv
// Top level of the interleaved multiphase PWM sequencer. It ties the
// configuration latch, the phase timer and one controller per channel.
// Assumes the period is at least 8 ticks.
module mphase_pwm_seq
    import mphase_pwm_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PW-1:0]     period_i,
    input  logic [CH_MAX-1:0] unused_i,
    input  logic [CH_MAX-1:0] turn_on_i,
    output logic [CH_MAX-1:0] pwm_o,
    output logic [CH_MAX-1:0] sample_o
);
    logic [PW-1:0]     period_w;
    logic [CNT_W-1:0]  nact_w;
    logic [CH_MAX-1:0] active_w;
    logic [PW-1:0]     step_w;
    logic [PW-1:0]     toff_w;
    logic [CH_MAX-1:0] tick_w;

    mphase_cfg_latch #(.PW(PW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .unused_i (unused_i),
        .period_o (period_w),
        .nact_o   (nact_w),
        .active_o (active_w),
        .step_o   (step_w),
        .toff_o   (toff_w)
    );

    mphase_phase_timer #(.PW(PW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_w),
        .step_i   (step_w),
        .nact_i   (nact_w),
        .active_i (active_w),
        .tick_o   (tick_w)
    );

    for (genvar g = 0; g < CH_MAX; g++) begin : g_ch
        mphase_chan_ctl #(.PW(PW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .active_i  (active_w[g]),
            .tick_i    (tick_w[g]),
            .toff_i    (toff_w),
            .turn_on_i (turn_on_i[g]),
            .pwm_o     (pwm_o[g]),
            .sample_o  (sample_o[g])
        );
    end
endmodule

// File: tb/mphase_pwm_seq_bench.sv
// Sweeps every strap setting, several periods and several request patterns.
// A cycle-by-cycle expectation is computed arithmetically from the requirements.
module mphase_pwm_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] period_i = 16'd12;
    logic [3:0] unused_i = 4'd0;
    logic [3:0] turn_on_i = 4'd0;
    logic [3:0] pwm_o;
    logic [3:0] sample_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mphase_pwm_seq u_mphase_pwm_seq (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .unused_i(unused_i),
        .turn_on_i(turn_on_i), .pwm_o(pwm_o), .sample_o(sample_o)
    );

    function automatic bit req_bit(int pat, int k, int ch);
        case (pat)
            0:       return 1'b1;
            1:       return ((k * 5 + ch * 3) % 7) < 2;
            default: return (((k / 3) + ch) % 2) == 1;
        endcase
    endfunction

    task automatic check(bit ok, string tag, int k, int ch, int act_p, int act_s,
                         int exp_p, int exp_s);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s edge %0d ch %0d: actual pwm=%0d smp=%0d expected pwm=%0d smp=%0d",
                     tag, k, ch, act_p, act_s, exp_p, exp_s);
        end
    endtask

    task automatic run_cfg(logic [3:0] straps, int per, int pat);
        int n, step, toff;
        int offs[4];
        int last_t[4];
        bit seen[4];
        bit epwm[4];
        bit esmp[4];
        logic [3:0] cur;
        rst_n = 1'b0;
        unused_i = straps;
        period_i = 16'(per);
        turn_on_i = 4'hF;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset.
        check(pwm_o == 4'd0 && sample_o == 4'd0, "R1", -1, 0, pwm_o, sample_o, 0, 0);
        // R2: channel count from straps, bit 2 overriding bit 3.
        n = straps[2] ? 2 : (straps[3] ? 3 : 4);
        step = (n == 4) ? per / 4 : ((n == 3) ? per / 3 : per / 2);
        toff = per / 3;
        for (int c = 0; c < 4; c++) begin
            offs[c] = (n - 1 - c) * step;
            seen[c] = 1'b0; epwm[c] = 1'b0; esmp[c] = 1'b0; last_t[c] = 0;
        end
        for (int c = 0; c < 4; c++) cur[c] = req_bit(pat, 0, c);
        turn_on_i = cur;
        rst_n = 1'b1;
        for (int k = 0; k < 3 * per + 12; k++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                string tag;
                esmp[c] = 1'b0;
                if (c >= n) begin
                    epwm[c] = 1'b0; tag = "R10";
                end else if (k >= offs[c] && ((k - offs[c]) % per) == 0) begin
                    // R6: terminations recur every period from the first one.
                    epwm[c] = 1'b0; last_t[c] = k; seen[c] = 1'b1;
                    tag = (n == 4) ? "R3" : ((n == 3) ? "R4" : "R5");
                end else if (seen[c] && (k - last_t[c]) < toff) begin
                    epwm[c] = 1'b0; tag = "R7";
                end else if (seen[c] && (k - last_t[c]) == toff) begin
                    epwm[c] = 1'b0; esmp[c] = 1'b1; tag = "R8";
                end else begin
                    if (cur[c]) epwm[c] = 1'b1;
                    tag = seen[c] ? "R9" : "R11";
                end
                check(pwm_o[c] == epwm[c] && sample_o[c] == esmp[c], tag, k, c,
                      pwm_o[c], sample_o[c], epwm[c], esmp[c]);
            end
            if (k == 4) begin
                // R1: later strap and period changes must not matter.
                unused_i = ~straps;
                period_i = 16'(per + 5);
            end
            for (int c = 0; c < 4; c++) cur[c] = req_bit(pat, k + 1, c);
            turn_on_i = cur;
        end
    endtask

    initial begin
        int pers[3];
        logic [3:0] strs[4];
        pers[0] = 12; pers[1] = 13; pers[2] = 17;
        strs[0] = 4'b0000; strs[1] = 4'b1000; strs[2] = 4'b0100; strs[3] = 4'b1100;
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 3; p++)
                for (int q = 0; q < 3; q++)
                    run_cfg(strs[s], pers[p], q);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule